// File: doc/BRIEF.md
# Two-Wire Bus Unjam Sequencer

This block helps a two-wire bus master recover after it and a slave disagree about where they are in a transfer and the slave is left holding the data line low. A one-clock request starts a recovery run. The block then takes over the clock line and produces a train of clock pulses. Each pulse pulls the clock line low for a programmable number of system clocks and then releases it for the same number. After each release the block looks at the data line. The run stops when the data line is seen high, or after nine pulses.

The outcome comes back as a one-clock done pulse, which carries either a success flag or a failure flag. On success the surrounding master may issue a START of its own. On failure the bus is still stuck. The block never drives the data line and does not create the START that follows. The clock-line output is an open-drain pull-down enable: 1 pulls the line low and 0 releases it.

Top module: `bus_unjam_top`

## Requirements
- R1: After reset, and whenever no run is active, scl_pull_o is 0 and busy_o, done_o, ok_o and stuck_o are 0.
- R2: A start_i high seen while idle begins a run. Each pulse holds scl_pull_o at 1 for H system clocks and then at 0 for H system clocks, where H is half_per_i, and a value of 0 is treated as 1. The first pull starts in the cycle after start_i is sampled.
- R3: sda_i passes through a two-flop synchroniser. The synchronised value is judged in the last system clock of each released phase.
- R4: When the judged data value is 1 on pulse k, no further pulse follows. done_o and ok_o are 1 exactly 2·H·k clocks after the cycle in which start_i was sampled.
- R5: If the data line is already high when a run starts, one full pulse is still issued and the run succeeds on it (k = 1).
- R6: If the judged value is 0 on all nine pulses, the run ends after exactly nine pulses, with done_o and stuck_o at 1 after 18·H clocks.
- R7: done_o is high for exactly one clock. When it is high, exactly one of ok_o and stuck_o is 1. Neither of them is 1 otherwise.
- R8: start_i is ignored while busy_o is 1. Such a request changes neither the pulse count nor the timing, and it does not cause a second run afterwards.
- R9: Asserting rst_n low during a run releases the clock line at once and ends the run with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery request, sampled while idle |
| half_per_i | input | 16 | Length of each clock-line phase in system clocks (0 acts as 1) |
| sda_i | input | 1 | Data line level as seen on the bus |
| scl_pull_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-clock end-of-run pulse |
| ok_o | output | 1 | Run ended with the data line released |
| stuck_o | output | 1 | Run ended after nine pulses with the data line still low |

## Verification
The hardest cases to reach are the ones where the data line lets go on a chosen pulse, above all the ninth. The bench models the stuck slave. It counts the pulls it sees on scl_pull_o and raises sda_i when the clock line is released on the chosen pulse. That places the release early enough inside the released phase for the synchroniser to deliver it before the judging clock. A request made in the middle of a run and a reset in the middle of a pull phase are placed by cycle index, counted from the accepted start.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PULL = 2'd1,
    PH_FREE = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_OK    = 2'd1,
    END_STUCK = 2'd2
  } outcome_e;
endpackage

// File: rtl/unjam_rst_sync.sv
module unjam_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/unjam_sync.sv
module unjam_sync #(
  parameter int   STAGES   = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = async_i;
      end else begin : g_rest
        always_comb stage_d[g] = stage_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/unjam_timer.sv
module unjam_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i)             cnt_d = load_val_i;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/unjam_ctrl.sv
module unjam_ctrl
  import unjam_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] half_per_i,
  input  logic             sda_s_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             scl_pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic             stuck_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] LAST_PULSE = PW'(MAX_PULSES);

  phase_e          ph_q, ph_d;
  logic [PW-1:0]   pulse_q, pulse_d;
  outcome_e        end_q, end_d;
  logic [CNT_W-1:0] half_eff;

  always_comb begin
    half_eff  = (half_per_i == '0) ? CNT_W'(1) : half_per_i;
    tmr_val_o = half_eff - 1'b1;
  end

  always_comb begin
    ph_d       = ph_q;
    pulse_d    = pulse_q;
    end_d      = END_NONE;
    tmr_load_o = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d       = PH_PULL;
          pulse_d    = PW'(1);
          tmr_load_o = 1'b1;
        end
      end
      PH_PULL: begin
        if (tmr_zero_i) begin
          ph_d       = PH_FREE;
          tmr_load_o = 1'b1;
        end
      end
      PH_FREE: begin
        if (tmr_zero_i) begin
          if (sda_s_i) begin
            ph_d  = PH_IDLE;
            end_d = END_OK;
          end else if (pulse_q == LAST_PULSE) begin
            ph_d  = PH_IDLE;
            end_d = END_STUCK;
          end else begin
            ph_d       = PH_PULL;
            pulse_d    = pulse_q + 1'b1;
            tmr_load_o = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      pulse_q <= '0;
      end_q   <= END_NONE;
    end else begin
      ph_q    <= ph_d;
      pulse_q <= pulse_d;
      end_q   <= end_d;
    end
  end

  assign scl_pull_o = (ph_q == PH_PULL);
  assign busy_o     = (ph_q != PH_IDLE);
  assign done_o     = (end_q != END_NONE);
  assign ok_o       = (end_q == END_OK);
  assign stuck_o    = (end_q == END_STUCK);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !scl_pull_o);

  // R2
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_o) |-> $past(tmr_zero_i));

  // R4
  ok_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(sda_s_i));

  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= LAST_PULSE);

  // R6
  stuck_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_o) |-> ($past(pulse_q) == LAST_PULSE));

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ok_o ^ stuck_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && ph_q == PH_PULL && !tmr_zero_i) |=> (ph_q == PH_PULL));
endmodule

// File: rtl/bus_unjam_top.sv
module bus_unjam_top #(
  parameter int CNT_W       = 16,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] half_per_i,
  input  logic             sda_i,
  output logic             scl_pull_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic             stuck_o
);
  logic             rst_n_i;
  logic             sda_s;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  unjam_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_i)
  );

  unjam_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .async_i (sda_i),
    .sync_o  (sda_s)
  );

  unjam_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  unjam_ctrl #(.CNT_W(CNT_W), .MAX_PULSES(MAX_PULSES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start_i    (start_i),
    .half_per_i (half_per_i),
    .sda_s_i    (sda_s),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .scl_pull_o (scl_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .stuck_o    (stuck_o)
  );

  // R9
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |-> !scl_pull_o);
endmodule

// File: tb/tb_bus_unjam_top.sv
module tb_bus_unjam_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] half_per_i;
  logic        sda_i;
  logic        scl_pull_o, busy_o, done_o, ok_o, stuck_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  bus_unjam_top dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_per_i(half_per_i),
    .sda_i(sda_i), .scl_pull_o(scl_pull_o), .busy_o(busy_o),
    .done_o(done_o), .ok_o(ok_o), .stuck_o(stuck_o)
  );

  // {half period, pulse on which the data line lets go (0 = already high, 10 = never)}
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {16'd3, 8'd1}, {16'd3, 8'd4}, {16'd5, 8'd9}, {16'd4, 8'd10},
    {16'd3, 8'd0}, {16'd0, 8'd0}, {16'd1, 8'd10}, {16'd7, 8'd2},
    {16'd2, 8'd0}
  };

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; sda_i = 1'b0; half_per_i = 16'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One run. poke_at >= 0 raises start_i again at that index (R8).
  task automatic run(input int h, input int rel, input int poke_at);
    int heff, expk, pulls, lowrun, idx, bad_low;
    bit prev_low, expok;
    heff  = (h == 0) ? 1 : h;
    expk  = (rel == 0) ? 1 : ((rel > 9) ? 9 : rel);
    expok = (rel <= 9);
    half_per_i = 16'(h);
    sda_i = (rel == 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0; pulls = 0; lowrun = 0; bad_low = 0; prev_low = 1'b0;
    while (!done_o && idx < 400) begin
      if (scl_pull_o && !prev_low) begin pulls++; lowrun = 0; end
      if (scl_pull_o) lowrun++;
      if (!scl_pull_o && prev_low) begin
        if (lowrun != heff) bad_low++;
        if (pulls == rel) sda_i = 1'b1;
      end
      if (idx == 0) chk(scl_pull_o && busy_o, "R2 first pull", scl_pull_o, 1);
      prev_low = scl_pull_o;
      start_i = (idx == poke_at);
      @(negedge clk);
      idx++;
    end
    start_i = 1'b0;
    // R2 every pull phase lasts H clocks
    chk(bad_low == 0, "R2 pull width", bad_low, 0);
    // R4 R6 pulse count and end time
    chk(pulls == expk, expok ? "R4 pulse count" : "R6 pulse count", pulls, expk);
    chk(idx == 2 * heff * expk, expok ? "R4 done time" : "R6 done time", idx, 2 * heff * expk);
    // R7 outcome flags
    chk(ok_o == expok && stuck_o == !expok, rel == 0 ? "R5 outcome" : "R7 outcome",
        {ok_o, stuck_o}, {expok, !expok});
    @(negedge clk);
    chk(!done_o && !ok_o && !stuck_o && !busy_o && !scl_pull_o, "R7 done one clock",
        {done_o, ok_o, stuck_o}, 0);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk(!scl_pull_o, "R1 scl released", scl_pull_o, 0);
    chk(!busy_o && !done_o, "R1 idle", {busy_o, done_o}, 0);
    chk(!ok_o && !stuck_o, "R1 no outcome", {ok_o, stuck_o}, 0);

    // R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      run(int'(VEC[i][23:8]), int'(VEC[i][7:0]), -1);
      repeat (3) @(negedge clk);
    end

    // R8 request during a run is ignored
    run(3, 3, 4);
    begin
      int lows = 0;
      for (int j = 0; j < 30; j++) begin
        if (scl_pull_o || busy_o) lows++;
        @(negedge clk);
      end
      chk(lows == 0, "R8 no second run", lows, 0);
    end

    // R9 reset in the middle of a pull phase
    half_per_i = 16'd6; sda_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(scl_pull_o, "R9 pulling before reset", scl_pull_o, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk(!scl_pull_o, "R9 immediate release", scl_pull_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int dn = 0;
      for (int j = 0; j < 40; j++) begin
        if (done_o || scl_pull_o) dn++;
        @(negedge clk);
      end
      chk(dn == 0, "R9 no done after abort", dn, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule